// File: doc/BRIEF.md
# Transactional Stripe Access Cache

This block sits in the memory stage of a pipeline that runs transactional code. It remembers which fixed-size stripes of shared memory the current transaction has already loaded from or stored to. Each access address is cut down to a stripe number by dropping the low address bits. The pair of stripe number and access kind (read or write) is then looked up across every entry at once. A hit means the transactional handler need not be called again for that stripe and kind.

When the handler is triggered, the pipeline issues an insert carrying the access address, the access kind and the instruction's two-bit prediction class. The insert is dropped when that class marks the instruction as touching many stripes and already invoked (value 3). It is also dropped when the same stripe/kind pair is already held. When all entries are in use, the oldest one is replaced in round-robin order. Two clear inputs empty the cache: one at the start of a transactional region and one on a context switch.

Top module: `stripe_access_cache`

## Requirements
- R1: The stripe number is the access address shifted right by STRIPE_LG bits (default 6, 64-byte stripes). Any two addresses with the same stripe number give the same lookup result, and addresses in different stripes never match each other.
- R2: Access kind is encoded as 0 for a read and 1 for a write. A hit needs both the stripe number and the kind to match, so a read entry never satisfies a write lookup and a write entry never satisfies a read lookup.
- R3: An insert whose prediction class equals 3 adds no entry and does not advance the replacement order.
- R4: Lookup is combinational. An accepted insert is not seen by a lookup in the same cycle and is seen from the next cycle on.
- R5: An insert of a stripe/kind pair that is already held adds no entry and does not advance the replacement order.
- R6: A region-start clear removes every entry, so all lookups miss from the next cycle on.
- R7: A context-switch clear removes every entry, so all lookups miss from the next cycle on.
- R8: When a clear and an insert arrive in the same cycle, the clear wins and the cache is empty in the next cycle.
- R9: The cache holds DEPTH entries (default 32). Once it is full, each accepted insert replaces the entry that was inserted earliest, and all other entries remain.
- R10: After a synchronous active-high reset, every lookup misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_vaddr | input | VA_W | Address of the access being looked up |
| lk_is_wr | input | 1 | Lookup access kind: 0 read, 1 write |
| lk_hit | output | 1 | Stripe/kind pair is present (combinational) |
| ins_valid | input | 1 | Insert request |
| ins_vaddr | input | VA_W | Address of the access to record |
| ins_is_wr | input | 1 | Insert access kind: 0 read, 1 write |
| ins_pclass | input | 2 | Prediction class of the instruction; 3 suppresses the insert |
| clr_region | input | 1 | Region-start clear |
| clr_ctx | input | 1 | Context-switch clear |

## Verification
The bench targets the places where a design slips quietly. It checks the first and last byte of a stripe against the first byte of the next stripe, which catches a wrong shift. It checks the opposite access kind on the same stripe, which catches a kind bit left out of the compare. It inserts a duplicate into a full cache and then inserts a fresh entry. A design that stores the duplicate or advances the pointer on it would evict the wrong entry, so the earliest entry would survive or a later one would vanish. It also tries an insert in the same cycle as a clear, and an insert with prediction class 3. A design that lets either through leaves a stale hit. A long random phase then compares the hit output against a queue model on every cycle.

// File: rtl/sac_pkg.sv
package sac_pkg;
  typedef enum logic {
    ACC_RD = 1'b0,
    ACC_WR = 1'b1
  } acc_e;

  localparam logic [1:0] PCLASS_MULTI_DONE = 2'd3;
endpackage

// File: rtl/sac_stripe_map.sv
module sac_stripe_map #(
  parameter int VA_W      = 32,
  parameter int STRIPE_LG = 6,
  localparam int KEY_W    = VA_W - STRIPE_LG + 1
) (
  input  logic [VA_W-1:0]  vaddr,
  input  sac_pkg::acc_e    kind,
  output logic [KEY_W-1:0] key
);
  // key = {stripe number, access kind}
  assign key = {vaddr[VA_W-1:STRIPE_LG], kind};
endmodule

// File: rtl/sac_victim_ptr.sv
module sac_victim_ptr #(
  parameter int DEPTH   = 32,
  localparam int IDX_W  = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             adv,
  output logic [IDX_W-1:0] ptr
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(DEPTH - 1);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      ptr <= '0;
    end else if (adv) begin
      ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
    end
  end

  // R9: each accepted insert moves the pointer one slot on, wrapping at DEPTH
  a_r9_ptr_step: assert property (@(posedge clk) disable iff (rst)
    (adv && !clr) |=> (ptr == (($past(ptr) == LAST) ? '0 : $past(ptr) + 1'b1)));

  // R3/R5: without an advance or clear the pointer holds
  a_r5_ptr_hold: assert property (@(posedge clk) disable iff (rst)
    (!adv && !clr) |=> $stable(ptr));
endmodule

// File: rtl/sac_entry_array.sv
module sac_entry_array #(
  parameter int KEY_W   = 27,
  parameter int DEPTH   = 32,
  localparam int IDX_W  = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [KEY_W-1:0] wr_key,
  input  logic [KEY_W-1:0] key_a,
  input  logic [KEY_W-1:0] key_b,
  output logic [DEPTH-1:0] match_a,
  output logic [DEPTH-1:0] match_b
);
  logic [KEY_W-1:0] keys [DEPTH];
  logic [DEPTH-1:0] valid_q;

  // key storage: no reset, written one slot at a time
  always_ff @(posedge clk) begin
    if (wr_en) begin
      keys[wr_idx] <= wr_key;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      valid_q <= '0;
    end else if (wr_en) begin
      valid_q[wr_idx] <= 1'b1;
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
    assign match_a[g] = valid_q[g] && (keys[g] == key_a);
    assign match_b[g] = valid_q[g] && (keys[g] == key_b);
  end

  // R6/R7: any clear leaves nothing valid
  a_r6_clear_empties: assert property (@(posedge clk) disable iff (rst)
    clr |=> (valid_q == '0));

  // R4: a written slot is valid on the following cycle
  a_r4_write_visible: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !clr) |=> valid_q[$past(wr_idx)]);

  // R5: no pair is ever stored twice
  a_r5_no_dup_a: assert property (@(posedge clk) disable iff (rst)
    $onehot0(match_a));
  a_r5_no_dup_b: assert property (@(posedge clk) disable iff (rst)
    $onehot0(match_b));
endmodule

// File: rtl/stripe_access_cache.sv
module stripe_access_cache #(
  parameter int VA_W      = 32,
  parameter int STRIPE_LG = 6,
  parameter int DEPTH     = 32,
  localparam int KEY_W    = VA_W - STRIPE_LG + 1,
  localparam int IDX_W    = $clog2(DEPTH)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [VA_W-1:0] lk_vaddr,
  input  logic            lk_is_wr,
  output logic            lk_hit,
  input  logic            ins_valid,
  input  logic [VA_W-1:0] ins_vaddr,
  input  logic            ins_is_wr,
  input  logic [1:0]      ins_pclass,
  input  logic            clr_region,
  input  logic            clr_ctx
);
  import sac_pkg::*;

  logic [KEY_W-1:0] lk_key, ins_key;
  logic [DEPTH-1:0] lk_match, ins_match;
  logic [IDX_W-1:0] victim;
  logic             clr_any, ins_dup, ins_take;

  sac_stripe_map #(.VA_W(VA_W), .STRIPE_LG(STRIPE_LG)) u_map_lk (
    .vaddr(lk_vaddr), .kind(acc_e'(lk_is_wr)), .key(lk_key));

  sac_stripe_map #(.VA_W(VA_W), .STRIPE_LG(STRIPE_LG)) u_map_ins (
    .vaddr(ins_vaddr), .kind(acc_e'(ins_is_wr)), .key(ins_key));

  assign clr_any  = clr_region || clr_ctx;
  assign ins_dup  = |ins_match;
  assign ins_take = ins_valid && !clr_any && !ins_dup
                    && (ins_pclass != PCLASS_MULTI_DONE);

  sac_victim_ptr #(.DEPTH(DEPTH)) u_ptr (
    .clk(clk), .rst(rst), .clr(clr_any), .adv(ins_take), .ptr(victim));

  sac_entry_array #(.KEY_W(KEY_W), .DEPTH(DEPTH)) u_arr (
    .clk(clk), .rst(rst), .clr(clr_any),
    .wr_en(ins_take), .wr_idx(victim), .wr_key(ins_key),
    .key_a(lk_key), .key_b(ins_key),
    .match_a(lk_match), .match_b(ins_match));

  assign lk_hit = |lk_match;

  // R3: an already-invoked multi-stripe instruction never moves the pointer
  a_r3_pclass_blocks: assert property (@(posedge clk) disable iff (rst)
    (ins_valid && ins_pclass == PCLASS_MULTI_DONE && !clr_any) |=> $stable(victim));

  // R8: clear in the same cycle as an insert leaves no hit at all
  a_r8_clear_wins: assert property (@(posedge clk) disable iff (rst)
    (clr_any && ins_valid) |=> !lk_hit);

  // R7: a context-switch clear leaves no hit
  a_r7_ctx_clear: assert property (@(posedge clk) disable iff (rst)
    clr_ctx |=> !lk_hit);
endmodule

// File: tb/sim_stripe_access_cache.sv
module sim_stripe_access_cache;
  localparam int VA_W = 32;
  localparam int SLG  = 6;
  localparam int DEP  = 32;

  logic            clk = 1'b0;
  logic            rst;
  logic [VA_W-1:0] lk_vaddr, ins_vaddr;
  logic            lk_is_wr, ins_is_wr, ins_valid, clr_region, clr_ctx, lk_hit;
  logic [1:0]      ins_pclass;

  int n_chk = 0, n_bad = 0;
  logic [VA_W-SLG:0] model_q[$];

  always #4 clk = ~clk;  // 125 MHz

  stripe_access_cache #(.VA_W(VA_W), .STRIPE_LG(SLG), .DEPTH(DEP)) u0 (
    .clk(clk), .rst(rst), .lk_vaddr(lk_vaddr), .lk_is_wr(lk_is_wr), .lk_hit(lk_hit),
    .ins_valid(ins_valid), .ins_vaddr(ins_vaddr), .ins_is_wr(ins_is_wr),
    .ins_pclass(ins_pclass), .clr_region(clr_region), .clr_ctx(clr_ctx));

  function automatic logic [VA_W-SLG:0] mkey(logic [VA_W-1:0] a, logic w);
    return {a[VA_W-1:SLG], w};
  endfunction

  function automatic bit model_has(logic [VA_W-SLG:0] k);
    foreach (model_q[i]) if (model_q[i] == k) return 1'b1;
    return 1'b0;
  endfunction

  task automatic check(string req, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s lk_hit actual=%0b expected=%0b at %0t", req, act, exp, $time);
    end
  endtask

  // one cycle: drive at negedge, compare before posedge, then advance the model
  task automatic step(string req, logic [VA_W-1:0] la, logic lw,
                      logic iv, logic [VA_W-1:0] ia, logic iw, logic [1:0] pc,
                      logic cr, logic cc);
    logic [VA_W-SLG:0] k;
    @(negedge clk);
    lk_vaddr = la; lk_is_wr = lw; ins_valid = iv; ins_vaddr = ia;
    ins_is_wr = iw; ins_pclass = pc; clr_region = cr; clr_ctx = cc;
    #3;
    check(req, lk_hit, model_has(mkey(la, lw)));
    k = mkey(ia, iw);
    if (cr || cc) model_q.delete();
    else if (iv && pc != 2'd3 && !model_has(k)) begin
      if (model_q.size() == DEP) void'(model_q.pop_front());
      model_q.push_back(k);
    end
  endtask

  task automatic look(string req, logic [VA_W-1:0] la, logic lw);
    step(req, la, lw, 1'b0, '0, 1'b0, 2'd0, 1'b0, 1'b0);
  endtask

  initial begin
    #1600000;
    n_bad++; n_chk++;
    $display("FAIL watchdog expired, actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    rst = 1'b1; lk_vaddr = '0; lk_is_wr = 0; ins_valid = 0; ins_vaddr = '0;
    ins_is_wr = 0; ins_pclass = 0; clr_region = 0; clr_ctx = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;

    look("R10", 32'h0000_1000, 1'b0);
    look("R10", 32'h0000_0000, 1'b1);
    // R4: insert read at 0x1000, same-cycle lookup misses
    step("R4", 32'h0000_1000, 1'b0, 1'b1, 32'h0000_1000, 1'b0, 2'd0, 1'b0, 1'b0);
    look("R4", 32'h0000_1000, 1'b0);
    look("R1", 32'h0000_103F, 1'b0);
    look("R1", 32'h0000_1040, 1'b0);
    look("R1", 32'h0000_0FFF, 1'b0);
    look("R2", 32'h0000_1000, 1'b1);
    step("R2", 32'h0, 1'b0, 1'b1, 32'h0000_2010, 1'b1, 2'd2, 1'b0, 1'b0);
    look("R2", 32'h0000_2000, 1'b1);
    look("R2", 32'h0000_2000, 1'b0);
    // R3: class 3 insert dropped
    step("R3", 32'h0, 1'b0, 1'b1, 32'h0000_3000, 1'b0, 2'd3, 1'b0, 1'b0);
    look("R3", 32'h0000_3000, 1'b0);
    // R6
    step("R6", 32'h0, 1'b0, 1'b0, '0, 1'b0, 2'd0, 1'b1, 1'b0);
    look("R6", 32'h0000_1000, 1'b0);
    look("R6", 32'h0000_2000, 1'b1);
    // R9 / R5: fill, duplicate, then one new entry
    for (int i = 0; i < DEP; i++)
      step("R9", 32'h0, 1'b0, 1'b1, 32'h0001_0000 + i * 64, i[0], 2'd1, 1'b0, 1'b0);
    look("R9", 32'h0001_0000, 1'b0);
    step("R5", 32'h0, 1'b0, 1'b1, 32'h0001_0000, 1'b0, 2'd0, 1'b0, 1'b0);
    step("R9", 32'h0, 1'b0, 1'b1, 32'h0002_0000, 1'b1, 2'd0, 1'b0, 1'b0);
    look("R5", 32'h0001_0000, 1'b0);
    look("R5", 32'h0001_0040, 1'b1);
    look("R9", 32'h0002_0000, 1'b1);
    look("R9", 32'h0001_07C0, 1'b1);
    // R7
    step("R7", 32'h0, 1'b0, 1'b0, '0, 1'b0, 2'd0, 1'b0, 1'b1);
    look("R7", 32'h0002_0000, 1'b1);
    look("R7", 32'h0001_0040, 1'b1);
    // R8
    step("R8", 32'h0, 1'b0, 1'b1, 32'h0000_5000, 1'b0, 2'd0, 1'b1, 1'b0);
    look("R8", 32'h0000_5000, 1'b0);
    // random phase against the queue model
    for (int c = 0; c < 4000; c++) begin
      int r = $urandom_range(0, 99);
      step("R9", 32'h0004_0000 + $urandom_range(0, 47) * 64 + $urandom_range(0, 63),
           1'($urandom), r < 60, 32'h0004_0000 + $urandom_range(0, 47) * 64,
           1'($urandom), 2'($urandom), r == 98, r == 99);
    end
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule